// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a 32,768 Hz oscillator enable (one clock-wide pulse per oscillator cycle) into a one-second tick, a minute tick and a 512 Hz test square wave. It corrects the crystal's rate digitally, with no analog trimming. A signed five-bit trim value picks some seconds of each 64-minute cycle. Each picked second is made shorter or longer by a fixed number of oscillator cycles, and every other second keeps its nominal length.

The block keeps its own second-within-minute and minute-within-cycle counters, so it knows where it stands in the trim cycle. The picked second is the first second of each of the first 2N minutes of the cycle, where N is the trim magnitude. A hold input freezes all counting. A restart strobe clears the sub-second chain and the test divider but keeps the position in the cycle. A calendar that needs a clean second boundary after a time write pulses this strobe.

Top module: `calib_prescaler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sec_tick`, `min_tick` and `ft_out` are low. Counting then starts at second 0 of minute 0 of the trim cycle.
- R2: A second that is not picked for correction lasts exactly OSC_HZ counted oscillator pulses. A trim magnitude of 0 picks no second, whichever sign is set.
- R3: With the sign bit `trim[5]` = 1 (speed up) and magnitude N = `trim[4:0]`, the first second of each minute m < 2N of the cycle lasts OSC_HZ − STAGE_DIV pulses.
- R4: With `trim[5]` = 0 (slow down), the same picked seconds last OSC_HZ + STAGE_DIV/2 pulses.
- R5: `min_tick` pulses together with the `sec_tick` that ends the last second (index SEC_PER_MIN−1) of a minute. The minute index of the trim cycle counts 0..63 and wraps from 63 to 0, so the correction pattern repeats every 64 minutes.
- R6: `ft_out` toggles after every OSC_HZ/(2·FT_HZ) counted pulses, starting low. It does not depend on the trim value.
- R7: Oscillator pulses that arrive while `hold` is high are not counted by either divider.
- R8: A `restart` pulse clears the sub-second count and the test divider (`ft_out` returns low), and it overrides an oscillator pulse in the same cycle. It leaves the second and minute position of the trim cycle unchanged.
- R9: `sec_tick` is a single-cycle pulse. It is registered and appears in the cycle after the clock edge that counts the last pulse of a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| hold | input | 1 | Freeze both dividers while high |
| restart | input | 1 | Clear the sub-second chain and the test divider |
| trim | input | 6 | [4:0] magnitude, [5] sign (1 = speed up) |
| sec_tick | output | 1 | One-second pulse |
| min_tick | output | 1 | Minute pulse, coincident with the last second tick of a minute |
| ft_out | output | 1 | Frequency-test square wave, taken ahead of the correction |

## Verification
The assertions assume that `trim` changes only in a cycle where `restart` is high. Otherwise a shortened terminal count could fall below a count already reached, and the bench's reference lengths would no longer be defined. The random stimulus honours this: every new trim value is applied together with a restart. Oscillator pulses, hold cycles and extra restarts are drawn freely in between. The bench runs at reduced parameters so that full 64-minute cycles fit, including the 63-to-0 wrap with magnitude 31.

// File: rtl/calpre_pkg.sv
package calpre_pkg;

    localparam int MAG_W       = 5;
    localparam int CYC_MINUTES = 64;
    localparam int MIN_W       = $clog2(CYC_MINUTES);

    typedef struct packed {
        logic             speed_up;
        logic [MAG_W-1:0] mag;
    } trim_t;

    // A minute of the cycle is corrected when it lies below twice the magnitude.
    function automatic logic minute_trimmed(logic [MIN_W-1:0] minute, trim_t t);
        return minute < {t.mag, 1'b0};
    endfunction

endpackage

// File: rtl/calpre_ft.sv
module calpre_ft #(
    parameter int FT_DIV = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    output logic ft_o
);
    localparam int HALF = FT_DIV / 2;
    localparam int CW   = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } ft_t;

    ft_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
            d.lvl = 1'b0;
        end else if (run_i) begin
            if (q.cnt == LAST) begin
                d.cnt = '0;
                d.lvl = ~q.lvl;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ft_o = q.lvl;

    // R6/R7: the test wave only moves after a counted pulse or a clear
    p_ft_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> $stable(q.lvl));
    // R8: a clear returns the wave low
    p_ft_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (q.lvl == 1'b0));
endmodule

// File: rtl/calpre_secdiv.sv
module calpre_secdiv #(
    parameter int OSC_HZ    = 32768,
    parameter int STAGE_DIV = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    input  logic trim_now_i,
    input  logic speed_up_i,
    output logic wrap_o,
    output logic tick_o
);
    localparam int LONG  = STAGE_DIV / 2;
    localparam int LEN_W = $clog2(OSC_HZ + LONG + 1);
    localparam logic [LEN_W-1:0] TC_NOM  = LEN_W'(OSC_HZ - 1);
    localparam logic [LEN_W-1:0] TC_FAST = LEN_W'(OSC_HZ - STAGE_DIV - 1);
    localparam logic [LEN_W-1:0] TC_SLOW = LEN_W'(OSC_HZ + LONG - 1);

    typedef struct packed {
        logic [LEN_W-1:0] sub;
        logic             tick;
    } div_t;

    div_t d, q;
    logic [LEN_W-1:0] tc;

    always_comb begin
        tc = TC_NOM;
        if (trim_now_i) tc = speed_up_i ? TC_FAST : TC_SLOW;
        wrap_o = run_i && !clr_i && (q.sub >= tc);
        d      = q;
        d.tick = wrap_o;
        if (clr_i)      d.sub = '0;
        else if (run_i) d.sub = wrap_o ? '0 : q.sub + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tick_o = q.tick;

    // R4: no second ever runs past the longest corrected length
    p_sub_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.sub <= TC_SLOW);
    // R9: the second tick lasts one cycle
    p_tick_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.tick |=> !q.tick);
    // R7: hold freezes the sub-second count
    p_hold_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> $stable(q.sub));
    // R8: restart clears the chain and suppresses a tick
    p_restart_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (q.sub == '0) && !q.tick);
endmodule

// File: rtl/calpre_seq.sv
module calpre_seq
    import calpre_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wrap_i,
    input  trim_t trim_i,
    output logic  trim_now_o,
    output logic  min_tick_o
);
    localparam int SEC_W = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(CYC_MINUTES - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] minute;
        logic             mtick;
    } seq_t;

    seq_t d, q;

    always_comb begin
        trim_now_o = (q.sec == '0) && minute_trimmed(q.minute, trim_i);
        d          = q;
        d.mtick    = 1'b0;
        if (wrap_i) begin
            if (q.sec == SEC_LAST) begin
                d.sec    = '0;
                d.mtick  = 1'b1;
                d.minute = (q.minute == MIN_LAST) ? '0 : q.minute + 1'b1;
            end else begin
                d.sec = q.sec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign min_tick_o = q.mtick;

    // R5: the minute index wraps from the top of the cycle back to zero
    p_cycle_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && q.sec == SEC_LAST && q.minute == MIN_LAST) |=> (q.minute == '0));
    // R8: with no second boundary the cycle position stays put
    p_pos_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(q.sec) && $stable(q.minute));
endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
    import calpre_pkg::*;
#(
    parameter int OSC_HZ      = 32768,
    parameter int STAGE_DIV   = 256,
    parameter int SEC_PER_MIN = 60,
    parameter int FT_HZ       = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       hold,
    input  logic       restart,
    input  logic [5:0] trim,
    output logic       sec_tick,
    output logic       min_tick,
    output logic       ft_out
);
    localparam int FT_DIV = OSC_HZ / FT_HZ;

    trim_t t;
    logic  run, wrap, trim_now;

    assign t   = trim_t'(trim);
    assign run = osc_en && !hold;

    calpre_secdiv #(.OSC_HZ(OSC_HZ), .STAGE_DIV(STAGE_DIV)) u_secdiv (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .run_i      (run),
        .clr_i      (restart),
        .trim_now_i (trim_now),
        .speed_up_i (t.speed_up),
        .wrap_o     (wrap),
        .tick_o     (sec_tick)
    );

    calpre_seq #(.SEC_PER_MIN(SEC_PER_MIN)) u_seq (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wrap_i     (wrap),
        .trim_i     (t),
        .trim_now_o (trim_now),
        .min_tick_o (min_tick)
    );

    calpre_ft #(.FT_DIV(FT_DIV)) u_ft (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .run_i  (run),
        .clr_i  (restart),
        .ft_o   (ft_out)
    );

    // R5: a minute tick never appears without its second tick
    p_min_with_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> sec_tick);
    // R9: a second boundary shows up on the tick one cycle later
    p_tick_follows_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> sec_tick);
endmodule

// File: tb/tb_calib_prescaler.sv
module tb_calib_prescaler;
    localparam int CLK_P  = 10;
    localparam int OSC    = 256;
    localparam int STG    = 32;
    localparam int SPM    = 2;
    localparam int FTHZ   = 32;
    localparam int FTH    = OSC / FTHZ / 2;
    localparam int WD_MAX = 199000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic osc_en = 1'b0, hold = 1'b0, restart = 1'b0;
    logic [5:0] trim = '0;
    logic sec_tick, min_tick, ft_out;

    calib_prescaler #(.OSC_HZ(OSC), .STAGE_DIV(STG), .SEC_PER_MIN(SPM), .FT_HZ(FTHZ)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .hold(hold), .restart(restart),
        .trim(trim), .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, bad = 0;
    int cnt = 0, ftk = 0, msec = 0, mmin = 0, cycles = 0;
    bit ovf = 0;
    logic p_en = 0, p_hold = 0, p_rst = 0;
    logic [5:0] p_trim = '0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(int s, int m, logic [5:0] c);
        if (s == 0 && m < 2 * int'(c[4:0]))
            return c[5] ? OSC - STG : OSC + STG / 2;
        return OSC;
    endfunction

    function automatic string len_req(int s, int m, logic [5:0] c);
        if (s == 0 && m < 2 * int'(c[4:0])) return c[5] ? "R3" : "R4";
        return "R2";
    endfunction

    task automatic step(bit en, bit st, bit dr, logic [5:0] c);
        int e;
        @(negedge clk);
        cycles++;
        if (p_rst) begin cnt = 0; ftk = 0; ovf = 0; end
        else if (p_en && !p_hold) begin cnt++; ftk++; end
        check(ft_out == ((ftk / FTH) % 2), "R6", ft_out, (ftk / FTH) % 2);
        e = exp_len(msec, mmin, p_trim);
        if (sec_tick) begin
            check(cnt == e, len_req(msec, mmin, p_trim), cnt, e);
            check(min_tick == (msec == SPM - 1), "R5", min_tick, msec == SPM - 1);
            if (msec == SPM - 1) begin msec = 0; mmin = (mmin + 1) % 64; end
            else msec++;
            cnt = 0; ovf = 0;
        end else begin
            if (min_tick) check(0, "R5", 1, 0);
            if (cnt > e && !ovf) begin
                ovf = 1;
                check(0, "R9", cnt, e);
            end
        end
        osc_en = en; hold = st; restart = dr; trim = c;
        p_en = en; p_hold = st; p_rst = dr; p_trim = c;
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_MAX, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [5:0] cur;
        void'($urandom(32'd4177));
        repeat (3) begin
            @(negedge clk);
            check(sec_tick == 0, "R1", sec_tick, 0);
            check(min_tick == 0, "R1", min_tick, 0);
            check(ft_out == 0, "R1", ft_out, 0);
        end
        rst_n = 1'b1;
        // R3: speed up, magnitude 3, across a whole cycle and its wrap
        cur = 6'h23;
        step(1, 0, 1, cur);
        for (int i = 0; i < 34000; i++) step(1, 0, 0, cur);
        // R4: slow down, magnitude 31, sparse pulses, minutes 62/63 unmodified
        cur = 6'h1F;
        step(0, 0, 1, cur);
        for (int i = 0; i < 40000; i++) step(($urandom % 8) != 0, 0, 0, cur);
        // R2: zero magnitude with either sign
        cur = 6'h20;
        step(1, 0, 1, cur);
        for (int i = 0; i < 3000; i++) step(1, 0, 0, cur);
        cur = 6'h00;
        step(1, 0, 1, cur);
        for (int i = 0; i < 3000; i++) step(1, 0, 0, cur);
        // R7/R8: random trims, hold bursts and extra restarts
        for (int k = 0; k < 50; k++) begin
            int len;
            cur = 6'($urandom);
            step($urandom % 2, 0, 1, cur);
            len = 200 + ($urandom % 800);
            for (int i = 0; i < len; i++)
                step(($urandom % 4) != 0, ($urandom % 10) == 0, ($urandom % 500) == 0, cur);
        end
        step(0, 0, 0, cur);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule